// File: doc/BRIEF.md
# BIOS Region Write-Enable Controller

This block is a small bank of chipset control registers that decides, cycle by cycle, whether host writes into the BIOS region of the SPI flash may proceed. A control byte carries a write-enable bit, a lock bit, a top-swap status bit and an SMM-only write-protect bit. Three further registers hold two SMI-source enables (a global one and a TCO one) and two freeze bits, and a one-bit sticky status records each SMI raised by the block.

Once the lock bit is set, any write to the control byte that requests write enable raises a one-cycle SMI request, provided both SMI sources are still enabled. An SMI handler can then react, for example by clearing write enable again. If the freeze bits are left clear, software can switch either source off and so suppress that SMI. When the SMM-only bit is set, writes are permitted only while the processor reports that it is in SMM.

Configuration writes arrive on a single-cycle write strobe with an address and a 16-bit data word. Reads are combinational from the same address lines.

Top module: `bios_wp_ctrl`

## Requirements
- R1: After reset, the control byte (address 0) reads 0x0000, the SMI enable register (address 1) reads 0x2001, the TCO control (address 2), PM config (address 3) and SMI status (address 4) registers read 0x0000, and smi_req and bios_wr_permit are 0.
- R2: The control byte has write enable at bit 0, lock at bit 1, top-swap status at bit 4 and SMM write-protect at bit 5. Write enable and top-swap take the written value. All other bits, and unmapped addresses, read 0.
- R3: Lock (control bit 1) and SMM write-protect (control bit 5) are set-once: writing 0 leaves them at 1 until reset.
- R4: If lock was already 1 and a control-byte write has bit 0 set while both SMI enables are 1, smi_req is high for exactly the one cycle after that write. The write still updates write enable.
- R5: No smi_req is raised when lock is 0, when the written bit 0 is 0, or when global enable (address 1 bit 0) or TCO enable (address 1 bit 13) is 0.
- R6: bios_wr_permit equals write enable when SMM write-protect is 0. When SMM write-protect is 1, it equals write enable AND in_smm, and it follows in_smm in the same cycle.
- R7: The TCO freeze bit (address 2 bit 12) and the SMI freeze bit (address 3 bit 4) are set-once. While the TCO freeze bit is 1, writes leave TCO enable unchanged. While the SMI freeze bit is 1, writes leave global enable unchanged.
- R8: SMI status (address 4 bit 0) sets at the end of each cycle in which smi_req is high. Writing 1 to it clears it, and writing 0 has no effect. If a clear and a set fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_smm | input | 1 | Processor is in System Management Mode |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Combinational read data for cfg_addr |
| smi_req | output | 1 | One-cycle SMI request |
| bios_wr_permit | output | 1 | BIOS region write allowed this cycle |

## Verification
Two things can fall in the same cycle: the status set caused by an SMI pulse, and a software write-1-to-clear of that status. The bench provokes this by issuing a locked write-enable attempt and then, on the very next cycle while smi_req is high, writing 1 to the status register. It then reads the status back and expects it to be 1, because the set takes priority. A second overlap is handled the same way: in_smm changes in the same cycle as the permit is sampled, and the bench checks that the permit follows in_smm in that cycle rather than one cycle later.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    localparam int CFG_DW = 16;
    localparam int CFG_AW = 3;

    // register addresses
    typedef enum logic [CFG_AW-1:0] {
        ADR_CTRL   = 3'd0,
        ADR_SMIEN  = 3'd1,
        ADR_TCOCTL = 3'd2,
        ADR_PMCFG  = 3'd3,
        ADR_SMISTS = 3'd4
    } cfg_addr_e;

    // bit positions that software decodes
    localparam int B_WEN      = 0;
    localparam int B_LOCK     = 1;
    localparam int B_TSWAP    = 4;
    localparam int B_SMMWP    = 5;
    localparam int B_GLB_EN   = 0;
    localparam int B_TCO_EN   = 13;
    localparam int B_TCO_LOCK = 12;
    localparam int B_SMI_LOCK = 4;
    localparam int B_STS      = 0;

    typedef struct packed {
        logic smm_wp;
        logic tswap;
        logic lock;
        logic wen;
    } ctrl_t;

    typedef struct packed {
        logic glb_en;
        logic tco_en;
        logic tco_lock;
        logic smi_lock;
    } smi_cfg_t;

    typedef struct packed {
        logic              valid;
        cfg_addr_e         addr;
        logic [CFG_DW-1:0] data;
    } cfg_wr_t;

    function automatic logic [CFG_DW-1:0] put_bit(input int pos, input logic v);
        logic [CFG_DW-1:0] r;
        r = '0;
        r[pos] = v;
        return r;
    endfunction

    function automatic logic [CFG_DW-1:0] pack_ctrl(input ctrl_t c);
        return put_bit(B_WEN, c.wen) | put_bit(B_LOCK, c.lock)
             | put_bit(B_TSWAP, c.tswap) | put_bit(B_SMMWP, c.smm_wp);
    endfunction

    function automatic logic hits(input cfg_wr_t w, input cfg_addr_e a);
        return w.valid && (w.addr == a);
    endfunction

endpackage

// File: rtl/bwc_ctrl_byte.sv
module bwc_ctrl_byte
    import bwc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cfg_wr_t wr,
    input  logic    in_smm,
    output ctrl_t   ctrl_q,
    output logic    wen_attempt,
    output logic    permit
);

    logic hit;

    always_comb begin
        hit         = hits(wr, ADR_CTRL);
        wen_attempt = hit && wr.data[B_WEN];
        permit      = ctrl_q.wen && (!ctrl_q.smm_wp || in_smm);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (hit) begin
            ctrl_q.wen    <= wr.data[B_WEN];
            ctrl_q.tswap  <= wr.data[B_TSWAP];
            ctrl_q.lock   <= ctrl_q.lock   | wr.data[B_LOCK];
            ctrl_q.smm_wp <= ctrl_q.smm_wp | wr.data[B_SMMWP];
        end
    end

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl_q.lock) |-> ctrl_q.lock);
    // R3
    smmwp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl_q.smm_wp) |-> ctrl_q.smm_wp);

endmodule

// File: rtl/bwc_smi_src.sv
module bwc_smi_src
    import bwc_pkg::*;
#(
    parameter logic GLB_RST = 1'b1,
    parameter logic TCO_RST = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  cfg_wr_t  wr,
    output smi_cfg_t cfg_q
);

    logic en_hit, tco_hit, pm_hit;

    always_comb begin
        en_hit  = hits(wr, ADR_SMIEN);
        tco_hit = hits(wr, ADR_TCOCTL);
        pm_hit  = hits(wr, ADR_PMCFG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.glb_en   <= GLB_RST;
            cfg_q.tco_en   <= TCO_RST;
            cfg_q.tco_lock <= 1'b0;
            cfg_q.smi_lock <= 1'b0;
        end else begin
            if (en_hit && !cfg_q.smi_lock) cfg_q.glb_en <= wr.data[B_GLB_EN];
            if (en_hit && !cfg_q.tco_lock) cfg_q.tco_en <= wr.data[B_TCO_EN];
            if (tco_hit) cfg_q.tco_lock <= cfg_q.tco_lock | wr.data[B_TCO_LOCK];
            if (pm_hit)  cfg_q.smi_lock <= cfg_q.smi_lock | wr.data[B_SMI_LOCK];
        end
    end

    // R7
    tco_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_q.tco_lock) |-> $stable(cfg_q.tco_en));
    // R7
    glb_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_q.smi_lock) |-> $stable(cfg_q.glb_en));
    // R7
    freeze_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_q.tco_lock) |-> cfg_q.tco_lock) and ($past(cfg_q.smi_lock) |-> cfg_q.smi_lock));

endmodule

// File: rtl/bwc_smi_event.sv
module bwc_smi_event (
    input  logic clk,
    input  logic rst,
    input  logic wen_attempt,
    input  logic locked,
    input  logic glb_en,
    input  logic tco_en,
    input  logic sts_clr,
    output logic smi_req,
    output logic sts_q
);

    logic fire;

    always_comb fire = wen_attempt && locked && glb_en && tco_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_req <= 1'b0;
            sts_q   <= 1'b0;
        end else begin
            smi_req <= fire;
            sts_q   <= (sts_q && !sts_clr) || smi_req;
        end
    end

    // R8
    sts_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        smi_req |=> sts_q);
    // R8
    sts_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sts_q) |-> $past(sts_clr));

endmodule

// File: rtl/bios_wp_ctrl.sv
module bios_wp_ctrl
    import bwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_smm,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              smi_req,
    output logic              bios_wr_permit
);

    cfg_wr_t  wr;
    ctrl_t    ctrl;
    smi_cfg_t scfg;
    logic     wen_attempt;
    logic     sts;

    always_comb begin
        wr.valid = cfg_wr;
        wr.addr  = cfg_addr_e'(cfg_addr);
        wr.data  = cfg_wdata;
    end

    bwc_ctrl_byte u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .in_smm      (in_smm),
        .ctrl_q      (ctrl),
        .wen_attempt (wen_attempt),
        .permit      (bios_wr_permit)
    );

    bwc_smi_src #(
        .GLB_RST (1'b1),
        .TCO_RST (1'b1)
    ) u_src (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .cfg_q (scfg)
    );

    bwc_smi_event u_evt (
        .clk         (clk),
        .rst         (rst),
        .wen_attempt (wen_attempt),
        .locked      (ctrl.lock),
        .glb_en      (scfg.glb_en),
        .tco_en      (scfg.tco_en),
        .sts_clr     (hits(wr, ADR_SMISTS) && cfg_wdata[B_STS]),
        .smi_req     (smi_req),
        .sts_q       (sts)
    );

    always_comb begin
        case (cfg_addr_e'(cfg_addr))
            ADR_CTRL:   cfg_rdata = pack_ctrl(ctrl);
            ADR_SMIEN:  cfg_rdata = put_bit(B_GLB_EN, scfg.glb_en) | put_bit(B_TCO_EN, scfg.tco_en);
            ADR_TCOCTL: cfg_rdata = put_bit(B_TCO_LOCK, scfg.tco_lock);
            ADR_PMCFG:  cfg_rdata = put_bit(B_SMI_LOCK, scfg.smi_lock);
            ADR_SMISTS: cfg_rdata = put_bit(B_STS, sts);
            default:    cfg_rdata = '0;
        endcase
    end

    // R4
    smi_cause_chk: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> $past(cfg_wr && cfg_addr == ADR_CTRL && cfg_wdata[B_WEN]));
    // R4
    smi_single_chk: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> !$past(smi_req) || $past(wen_attempt, 1));
    // R6
    smm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (bios_wr_permit && ctrl.smm_wp) |-> in_smm);

endmodule

// File: tb/tb_bios_wp_ctrl.sv
`timescale 1ns/1ps
module tb_bios_wp_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_smm = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        smi_req;
    logic        bios_wr_permit;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int          sel;   // 0 rdata, 1 permit, 2 smi_req
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    bios_wp_ctrl dut (
        .clk            (clk),
        .rst            (rst),
        .in_smm         (in_smm),
        .cfg_wr         (cfg_wr),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .cfg_rdata      (cfg_rdata),
        .smi_req        (smi_req),
        .bios_wr_permit (bios_wr_permit)
    );

    localparam logic [2:0] A_CTRL = 3'd0, A_EN = 3'd1, A_TCO = 3'd2, A_PM = 3'd3, A_STS = 3'd4;

    // monitor: compares everything queued for this cycle at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] got;
                it = sb.pop_front();
                case (it.sel)
                    0:       got = cfg_rdata;
                    1:       got = {15'd0, bios_wr_permit};
                    default: got = {15'd0, smi_req};
                endcase
                n_vec++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d got=0x%04h exp=0x%04h", it.req, it.sel, got, it.exp);
                end
            end
        end
    end

    task automatic step(input logic w, input logic [2:0] a, input logic [15:0] d);
        @(posedge clk);
        #1;
        cfg_wr = w; cfg_addr = a; cfg_wdata = d;
    endtask

    task automatic expect_v(input int sel, input logic [15:0] v, input string req);
        item_t it;
        it.sel = sel; it.exp = v; it.req = req;
        sb.push_back(it);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        step(0, A_CTRL, 0); expect_v(0, 16'h0000, "R1"); expect_v(1, 0, "R1"); expect_v(2, 0, "R1");
        step(0, A_EN, 0);   expect_v(0, 16'h2001, "R1");
        step(0, A_TCO, 0);  expect_v(0, 16'h0000, "R1");
        step(0, A_PM, 0);   expect_v(0, 16'h0000, "R1");
        step(0, A_STS, 0);  expect_v(0, 16'h0000, "R1");

        // R2 plain bits, R5 no SMI while unlocked
        step(1, A_CTRL, 16'h0011);
        step(0, A_CTRL, 0); expect_v(0, 16'h0011, "R2"); expect_v(1, 1, "R2 R6"); expect_v(2, 0, "R5");
        step(1, A_CTRL, 16'hFFC4);
        step(0, A_CTRL, 0); expect_v(0, 16'h0000, "R2"); expect_v(1, 0, "R6");
        step(0, 3'd6, 0);   expect_v(0, 16'h0000, "R2");

        // R3 lock, R4 locked attempt
        step(1, A_CTRL, 16'h0002);
        step(0, A_CTRL, 0); expect_v(0, 16'h0002, "R3"); expect_v(2, 0, "R5");
        step(1, A_CTRL, 16'h0001);
        step(0, A_CTRL, 0); expect_v(0, 16'h0003, "R3"); expect_v(2, 1, "R4"); expect_v(1, 1, "R4");
        step(0, A_STS, 0);  expect_v(2, 0, "R4"); expect_v(0, 16'h0001, "R8");
        step(1, A_STS, 16'h0000);
        step(0, A_STS, 0);  expect_v(0, 16'h0001, "R8");
        step(1, A_STS, 16'h0001);
        step(0, A_STS, 0);  expect_v(0, 16'h0000, "R8");

        // R5 each enable suppresses the SMI
        step(1, A_EN, 16'h0001);
        step(0, A_EN, 0);   expect_v(0, 16'h0001, "R5");
        step(1, A_CTRL, 16'h0001);
        step(0, A_CTRL, 0); expect_v(2, 0, "R5");
        step(1, A_EN, 16'h2000);
        step(1, A_CTRL, 16'h0001);
        step(0, A_CTRL, 0); expect_v(2, 0, "R5");
        step(1, A_EN, 16'h2001);
        step(0, A_EN, 0);   expect_v(0, 16'h2001, "R5");

        // R7 freezes
        step(1, A_TCO, 16'h1000);
        step(0, A_TCO, 0);  expect_v(0, 16'h1000, "R7");
        step(1, A_EN, 16'h0001);
        step(0, A_EN, 0);   expect_v(0, 16'h2001, "R7");
        step(1, A_TCO, 16'h0000);
        step(0, A_TCO, 0);  expect_v(0, 16'h1000, "R7");
        step(1, A_PM, 16'h0010);
        step(0, A_PM, 0);   expect_v(0, 16'h0010, "R7");
        step(1, A_EN, 16'h0000);
        step(0, A_EN, 0);   expect_v(0, 16'h2001, "R7");

        // R8 set and clear in the same cycle: set wins
        step(1, A_CTRL, 16'h0001);
        step(1, A_STS, 16'h0001); expect_v(2, 1, "R8");
        step(0, A_STS, 0);  expect_v(0, 16'h0001, "R8");
        step(1, A_STS, 16'h0001);
        step(0, A_STS, 0);  expect_v(0, 16'h0000, "R8");

        // R6 SMM-only writes, R3 smm_wp sticky
        step(1, A_CTRL, 16'h0020);
        step(0, A_CTRL, 0); expect_v(0, 16'h0022, "R6"); expect_v(1, 0, "R6"); expect_v(2, 0, "R5");
        step(1, A_CTRL, 16'h0021);
        step(0, A_CTRL, 0); expect_v(0, 16'h0023, "R6"); expect_v(1, 0, "R6"); expect_v(2, 1, "R4");
        step(0, A_CTRL, 0); in_smm = 1'b1; expect_v(1, 1, "R6");
        step(0, A_CTRL, 0); in_smm = 1'b0; expect_v(1, 0, "R6");
        step(1, A_CTRL, 16'h0000);
        step(0, A_CTRL, 0); in_smm = 1'b1; expect_v(0, 16'h0022, "R3"); expect_v(1, 0, "R6");
        step(0, A_CTRL, 0); in_smm = 1'b0;

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule